// File: doc/BRIEF.md
# Register Result-Latency Scoreboard

This block keeps, for each of sixteen architectural registers, a countdown of the cycles left before the most recent result written to that register can be used. When an instruction is issued, the issue logic names its destination register and its producer class. The scoreboard loads the default result latency of that class into the register's entry and records the class. Each entry then counts down by one every cycle and stops at zero.

Consumers present up to two source registers at once, each tagged with a consumer kind. The wait depends on the pair of classes, not only on the producer. The block compares the producer recorded for the register with the consumer kind and applies a shortened latency where forwarding allows one: a late-reading ALU operand, a multiply-accumulate accumulator input or a store data operand. For each source it reports the remaining wait and a ready flag, and it reports an overall ready when every valid source is ready.

Top module: `rsb_scoreboard`

## Requirements
- R1: After reset every entry holds a count of zero, so every source reports wait 0 and ready, and all_ready is 1.
- R2: Producer class codes on iss_class and their default latencies: 0 none 0, 1 ALU/shift 2, 2 move 1, 3 single/double load 3, 4 load multiple 5, 5 multiply 6, 6 multiply-accumulate 6, 7 long multiply 7, 8 short word-by-halfword multiply 5, 9 dual long multiply-accumulate 6, 10 store 0, 11 branch 0, 12 call 32. In the first cycle after issue, a consumer of kind 1 (early ALU operand) or kind 4 (store address) reads a wait equal to the default latency.
- R3: With no new write, an entry's wait drops by one each cycle and saturates at zero.
- R4: An issue takes effect from the cycle after the clock edge, overwrites the pending count and class of that register, and lookups in the same cycle as the issue still see the previous state.
- R5: For consumer kind 0 (ALU operand read late), the wait seen in the first cycle after issue is the bypass latency: move 0, ALU/shift 1, single/double load 2, load multiple 4, any multiply class (codes 5 to 9) 4. Other producers use their default latency.
- R6: For consumer kind 2 (accumulator input), a multiply, multiply-accumulate or short multiply producer gives a wait of 1. Long multiply and dual long multiply-accumulate keep their default latency.
- R7: For consumer kind 3 (store data), an ALU/shift or move producer gives a wait of 0; every other producer uses its default latency.
- R8: A consumer of kind 1 or kind 4 always waits the producer's default latency, with no bypass shortening.
- R9: Each source reports ready when it is not valid or its wait is zero; an invalid source reports wait 0. all_ready is the AND of the per-source ready flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iss_valid | input | 1 | An instruction writing a register is issued this cycle |
| iss_dst | input | 4 | Destination register of the issued instruction |
| iss_class | input | 4 | Producer class code of the issued instruction |
| src_valid | input | 2 | Per-source valid flags |
| src_reg | input | 8 | Source register numbers, source 0 in bits 3:0 |
| src_kind | input | 6 | Consumer kind codes, source 0 in bits 2:0 |
| src_wait | output | 12 | Remaining wait per source, source 0 in bits 5:0 |
| src_ready | output | 2 | Per-source ready flags |
| all_ready | output | 1 | All valid sources are ready |

## Verification
An issue to a register and a lookup of that same register can fall in the same cycle, and two writes to one register can land on consecutive edges while its old count is still running. The bench presents a source read of a register in the very cycle a new producer is issued to it. The read must show the old state before the edge and the new default or bypass wait after the edge. It also re-issues a register holding a long call latency with a move and requires the short count to replace the long one rather than merge with it.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    localparam int CNT_W  = 6;
    localparam int PCLS_W = 4;
    localparam int KIND_W = 3;

    typedef enum logic [PCLS_W-1:0] {
        PC_NONE   = 4'd0,
        PC_ALU    = 4'd1,
        PC_MOVE   = 4'd2,
        PC_LOAD   = 4'd3,
        PC_LDM    = 4'd4,
        PC_MUL    = 4'd5,
        PC_MAC    = 4'd6,
        PC_MULL   = 4'd7,
        PC_MULWH  = 4'd8,
        PC_MACL   = 4'd9,
        PC_STORE  = 4'd10,
        PC_BRANCH = 4'd11,
        PC_CALL   = 4'd12
    } pcls_t;

    typedef enum logic [KIND_W-1:0] {
        CK_ALU_LATE  = 3'd0,
        CK_ALU_EARLY = 3'd1,
        CK_MAC_ACC   = 3'd2,
        CK_ST_DATA   = 3'd3,
        CK_ST_ADDR   = 3'd4
    } ckind_t;

    typedef struct packed {
        logic [CNT_W-1:0] rem;
        pcls_t            cls;
    } entry_t;

    // Latency a producer needs before any consumer may use its result.
    function automatic logic [CNT_W-1:0] default_lat(pcls_t c);
        case (c)
            PC_ALU:   return CNT_W'(2);
            PC_MOVE:  return CNT_W'(1);
            PC_LOAD:  return CNT_W'(3);
            PC_LDM:   return CNT_W'(5);
            PC_MUL:   return CNT_W'(6);
            PC_MAC:   return CNT_W'(6);
            PC_MULL:  return CNT_W'(7);
            PC_MULWH: return CNT_W'(5);
            PC_MACL:  return CNT_W'(6);
            PC_CALL:  return CNT_W'(32);
            default:  return CNT_W'(0);
        endcase
    endfunction

    // Latency for a given producer/consumer pairing; never above default.
    function automatic logic [CNT_W-1:0] pair_lat(pcls_t c, ckind_t k);
        logic [CNT_W-1:0] lat;
        lat = default_lat(c);
        case (k)
            CK_ALU_LATE: begin
                case (c)
                    PC_MOVE: lat = CNT_W'(0);
                    PC_ALU:  lat = CNT_W'(1);
                    PC_LOAD: lat = CNT_W'(2);
                    PC_LDM, PC_MUL, PC_MAC, PC_MULL, PC_MULWH, PC_MACL:
                             lat = CNT_W'(4);
                    default: ;
                endcase
            end
            CK_MAC_ACC: begin
                if (c == PC_MUL || c == PC_MAC || c == PC_MULWH) lat = CNT_W'(1);
            end
            CK_ST_DATA: begin
                if (c == PC_ALU || c == PC_MOVE) lat = CNT_W'(0);
            end
            default: ;
        endcase
        return lat;
    endfunction

endpackage

// File: rtl/rsb_entry.sv
module rsb_entry
    import rsb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  pcls_t            wr_cls,
    output logic [CNT_W-1:0] rem_o,
    output pcls_t            cls_o
);

    entry_t ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (ent_q.rem != '0) begin
            ent_d.rem = ent_q.rem - CNT_W'(1);
        end
        if (wr_en) begin
            ent_d.rem = default_lat(wr_cls);
            ent_d.cls = wr_cls;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_q <= '{rem: '0, cls: PC_NONE};
        end else begin
            ent_q <= ent_d;
        end
    end

    assign rem_o = ent_q.rem;
    assign cls_o = ent_q.cls;

endmodule

// File: rtl/rsb_wait_calc.sv
module rsb_wait_calc
    import rsb_pkg::*;
(
    input  logic             valid_i,
    input  logic [CNT_W-1:0] rem_i,
    input  pcls_t            cls_i,
    input  ckind_t           kind_i,
    output logic [CNT_W-1:0] wait_o,
    output logic             ready_o
);

    logic [CNT_W-1:0] saved;   // cycles the bypass removes from the count

    always_comb begin
        saved = default_lat(cls_i) - pair_lat(cls_i, kind_i);
        if (!valid_i || rem_i <= saved) begin
            wait_o = '0;
        end else begin
            wait_o = rem_i - saved;
        end
        ready_o = (wait_o == '0);
    end

endmodule

// File: rtl/rsb_scoreboard.sv
module rsb_scoreboard
    import rsb_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int NUM_SRC  = 2,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       iss_valid,
    input  logic [IDX_W-1:0]           iss_dst,
    input  logic [PCLS_W-1:0]          iss_class,
    input  logic [NUM_SRC-1:0]         src_valid,
    input  logic [NUM_SRC*IDX_W-1:0]   src_reg,
    input  logic [NUM_SRC*KIND_W-1:0]  src_kind,
    output logic [NUM_SRC*CNT_W-1:0]   src_wait,
    output logic [NUM_SRC-1:0]         src_ready,
    output logic                       all_ready
);

    logic [CNT_W-1:0] rem_arr [NUM_REGS];
    pcls_t            cls_arr [NUM_REGS];
    pcls_t            iss_cls;

    assign iss_cls = pcls_t'(iss_class);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        rsb_entry u_entry (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (iss_valid && (iss_dst == IDX_W'(g))),
            .wr_cls (iss_cls),
            .rem_o  (rem_arr[g]),
            .cls_o  (cls_arr[g])
        );
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic [IDX_W-1:0] idx;
        assign idx = src_reg[s*IDX_W +: IDX_W];

        rsb_wait_calc u_calc (
            .valid_i (src_valid[s]),
            .rem_i   (rem_arr[idx]),
            .cls_i   (cls_arr[idx]),
            .kind_i  (ckind_t'(src_kind[s*KIND_W +: KIND_W])),
            .wait_o  (src_wait[s*CNT_W +: CNT_W]),
            .ready_o (src_ready[s])
        );
    end

    assign all_ready = &src_ready;

endmodule

// File: rtl/rsb_scoreboard_chk.sv
module rsb_scoreboard_chk
    import rsb_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int NUM_SRC  = 2,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       iss_valid,
    input  logic [IDX_W-1:0]           iss_dst,
    input  logic [PCLS_W-1:0]          iss_class,
    input  logic [NUM_SRC-1:0]         src_valid,
    input  logic [NUM_SRC*IDX_W-1:0]   src_reg,
    input  logic [NUM_SRC*KIND_W-1:0]  src_kind,
    input  logic [NUM_SRC*CNT_W-1:0]   src_wait,
    input  logic [NUM_SRC-1:0]         src_ready,
    input  logic                       all_ready
);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
        logic [IDX_W-1:0]  reg_s;
        logic [KIND_W-1:0] kind_s;
        logic [CNT_W-1:0]  wait_s;
        assign reg_s  = src_reg[s*IDX_W +: IDX_W];
        assign kind_s = src_kind[s*KIND_W +: KIND_W];
        assign wait_s = src_wait[s*CNT_W +: CNT_W];

        // R2, R8: an early reader right after issue sees the full default latency
        p_issue_default_r2: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid |=> (!(src_valid[s] && reg_s == $past(iss_dst) && kind_s == KIND_W'(1))
                           || wait_s == $past(default_lat(pcls_t'(iss_class)))));

        // R3: unchanged lookup with no new write counts down, stopping at zero
        p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(src_valid[s]) && src_valid[s] && reg_s == $past(reg_s)
             && kind_s == $past(kind_s) && !($past(iss_valid) && $past(iss_dst) == reg_s))
            |-> wait_s == (($past(wait_s) == '0) ? '0 : $past(wait_s) - CNT_W'(1)));

        // R2: no wait exceeds the longest default latency
        p_wait_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
            wait_s <= CNT_W'(32));

        // R9: an invalid source is ready with no wait
        p_idle_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !src_valid[s] |-> (src_ready[s] && wait_s == '0));

        // R9: a busy valid source blocks the overall ready
        p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (src_valid[s] && wait_s != '0) |-> (!all_ready && !src_ready[s]));
    end

endmodule

bind rsb_scoreboard rsb_scoreboard_chk #(
    .NUM_REGS (NUM_REGS),
    .NUM_SRC  (NUM_SRC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_dst   (iss_dst),
    .iss_class (iss_class),
    .src_valid (src_valid),
    .src_reg   (src_reg),
    .src_kind  (src_kind),
    .src_wait  (src_wait),
    .src_ready (src_ready),
    .all_ready (all_ready)
);

// File: tb/rsb_scoreboard_test.sv
module rsb_scoreboard_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [3:0]  iss_dst = '0;
    logic [3:0]  iss_class = '0;
    logic [1:0]  src_valid = '0;
    logic [7:0]  src_reg = '0;
    logic [5:0]  src_kind = '0;
    logic [11:0] src_wait;
    logic [1:0]  src_ready;
    logic        all_ready;

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic [3:0] cls;
        logic [2:0] kind;
        logic [5:0] byp;   // wait in first cycle after issue for this kind
        logic [5:0] dflt;  // default latency of the class
    } vec_t;

    // cls, kind, expected bypass wait, default latency (from R2, R5-R8)
    localparam vec_t VEC [NVEC] = '{
        '{4'd1,  3'd0, 6'd1,  6'd2},   // R5 ALU -> late ALU
        '{4'd2,  3'd0, 6'd0,  6'd1},   // R5 move -> late ALU
        '{4'd3,  3'd0, 6'd2,  6'd3},   // R5 load
        '{4'd4,  3'd0, 6'd4,  6'd5},   // R5 load multiple
        '{4'd5,  3'd0, 6'd4,  6'd6},   // R5 multiply
        '{4'd6,  3'd0, 6'd4,  6'd6},
        '{4'd7,  3'd0, 6'd4,  6'd7},
        '{4'd8,  3'd0, 6'd4,  6'd5},
        '{4'd9,  3'd0, 6'd4,  6'd6},
        '{4'd5,  3'd2, 6'd1,  6'd6},   // R6 accumulator bypass
        '{4'd6,  3'd2, 6'd1,  6'd6},
        '{4'd8,  3'd2, 6'd1,  6'd5},
        '{4'd7,  3'd2, 6'd7,  6'd7},   // R6 long multiply: no bypass
        '{4'd9,  3'd2, 6'd6,  6'd6},   // R6 dual long mac: no bypass
        '{4'd1,  3'd3, 6'd0,  6'd2},   // R7 store data
        '{4'd2,  3'd3, 6'd0,  6'd1},
        '{4'd3,  3'd3, 6'd3,  6'd3},
        '{4'd1,  3'd4, 6'd2,  6'd2},   // R8 store address
        '{4'd2,  3'd4, 6'd1,  6'd1},
        '{4'd12, 3'd0, 6'd32, 6'd32},  // R2 call
        '{4'd10, 3'd0, 6'd0,  6'd0},   // R2 store produces nothing
        '{4'd11, 3'd1, 6'd0,  6'd0},   // R2 branch
        '{4'd1,  3'd1, 6'd2,  6'd2}    // R8 early ALU
    };

    rsb_scoreboard uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_valid (iss_valid),
        .iss_dst   (iss_dst),
        .iss_class (iss_class),
        .src_valid (src_valid),
        .src_reg   (src_reg),
        .src_kind  (src_kind),
        .src_wait  (src_wait),
        .src_ready (src_ready),
        .all_ready (all_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic int sat(int v);
        return (v < 0) ? 0 : v;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step();
        step();
        // R1: reset state, all registers idle
        rst_n = 1'b1;
        src_valid = 2'b11;
        for (int r = 0; r < 16; r++) begin
            src_reg = {4'(r), 4'(r)};
            src_kind = {3'd1, 3'd4};
            #1;
            check("R1 wait0", int'(src_wait[5:0]), 0);
            check("R1 ready", int'({src_ready, all_ready}), 7);
        end

        // Table walk: R2, R5, R6, R7, R8 and R3 countdown
        for (int i = 0; i < NVEC; i++) begin
            step();
            iss_valid = 1'b1; iss_dst = 4'd5; iss_class = VEC[i].cls;
            src_valid = 2'b00;
            step();
            iss_valid = 1'b0;
            src_valid = 2'b11;
            src_reg = {4'd5, 4'd5};
            src_kind = {3'd1, VEC[i].kind};
            #1;
            check("R5/R6/R7/R8 pair wait", int'(src_wait[5:0]), int'(VEC[i].byp));
            check("R2 default wait", int'(src_wait[11:6]), int'(VEC[i].dflt));
            check("R9 ready", int'(src_ready[0]), (VEC[i].byp == 0) ? 1 : 0);
            step();
            step();
            #1;
            check("R3 countdown", int'(src_wait[5:0]), sat(int'(VEC[i].byp) - 2));
            check("R3 countdown early", int'(src_wait[11:6]), sat(int'(VEC[i].dflt) - 2));
        end

        // R3: saturation after a long idle period
        src_valid = 2'b01; src_reg = {4'd0, 4'd5}; src_kind = {3'd0, 3'd1};
        for (int k = 0; k < 40; k++) step();
        #1;
        check("R3 saturate", int'(src_wait[5:0]), 0);

        // R4: same-cycle issue and lookup of reg 7
        step();
        iss_valid = 1'b1; iss_dst = 4'd7; iss_class = 4'd1;
        src_valid = 2'b01; src_reg = {4'd0, 4'd7}; src_kind = {3'd0, 3'd1};
        #1;
        check("R4 old state before edge", int'(src_wait[5:0]), 0);
        step();
        iss_valid = 1'b0;
        #1;
        check("R4 new state after edge", int'(src_wait[5:0]), 2);

        // R4: call then move overwrite on reg 3
        step();
        iss_valid = 1'b1; iss_dst = 4'd3; iss_class = 4'd12;
        step();
        iss_class = 4'd2;
        src_reg = {4'd0, 4'd3}; src_kind = {3'd0, 3'd1};
        #1;
        check("R4 call pending", int'(src_wait[5:0]), 32);
        step();
        iss_valid = 1'b0;
        #1;
        check("R4 overwrite by move", int'(src_wait[5:0]), 1);
        src_kind = {3'd0, 3'd3};
        #1;
        check("R4 move class for store data", int'(src_wait[5:0]), 0);

        // R9: mixed sources and invalid source
        step();
        iss_valid = 1'b1; iss_dst = 4'd9; iss_class = 4'd7;
        step();
        iss_valid = 1'b0;
        src_valid = 2'b11; src_reg = {4'd2, 4'd9}; src_kind = {3'd1, 3'd1};
        #1;
        check("R9 src ready pattern", int'(src_ready), 2);
        check("R9 all_ready low", int'(all_ready), 0);
        src_valid = 2'b10;
        #1;
        check("R9 invalid source wait", int'(src_wait[5:0]), 0);
        check("R9 all_ready high", int'(all_ready), 1);

        // R1: reset in mid-run clears a pending entry
        step();
        iss_valid = 1'b1; iss_dst = 4'd4; iss_class = 4'd12;
        step();
        iss_valid = 1'b0;
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        src_valid = 2'b01; src_reg = {4'd0, 4'd4}; src_kind = {3'd0, 3'd1};
        #1;
        check("R1 reset clears entry", int'(src_wait[5:0]), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule